// File: doc/BRIEF.md
# Configurable GPIO pin controller

This block owns a single general-purpose pad and is steered by one 16-bit control word. The word selects whether the pin listens or drives, whether a driven high is pushed or left to an external pull-up, whether the pad is tri-stated, which logic sense the pin uses, which edges raise an interrupt, and which function the pin serves. The pull setting and the supply-domain choice are kept in the word and handed to the pad, and the block does nothing else with them.

Pad input passes through a two-flop synchroniser and then a de-bounce filter. The filter uses a short window for most function codes and a long window for one of them. The filtered level is turned into an active-high value according to the polarity bit. Its edges set a sticky interrupt flag, which software clears with a one-cycle strobe. For function codes outside plain GPIO use, the filtered level appears on a request output and no interrupt is raised.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: Out of reset the control word reads 0xA400. A write stores bits 15:9, 7 and 3:0 and the next read returns them in the same positions. Bits 8, 6, 5 and 4 always read 0.
- R2: Bit 15 = 1 selects input and forces `pad_oe` low. Bit 15 = 0 with bit 7 = 1 and push-pull drive sets `pad_oe` high.
- R3: Bit 10 = 1 means active high: the pad level is `out_val` and `in_level` is the filtered pad value. Bit 10 = 0 inverts both paths.
- R4: Bit 7 = 0 holds `pad_oe` low regardless of direction.
- R5: Bit 9 = 1 selects open-drain. `pad_out` is then always 0, and `pad_oe` is high only when the polarity-adjusted drive level is 0.
- R6: `pad_pull` mirrors bits 14:13 (reset 01) and `pad_dom_sel` mirrors bit 11.
- R7: A pad change reaches `in_level` only after the synchronised value has differed from the filtered one for 4 consecutive cycles. When bits 3:0 = 0, 64 cycles are needed instead. Shorter pulses are dropped. The filtered pad value resets to 0.
- R8: With bit 12 = 0, only a rising edge of `in_level` caused by the pad sets the interrupt. With bit 12 = 1, both edges do. A write to the polarity bit alone sets nothing.
- R9: `irq_flag` stays set until a cycle with `irq_clear` high. If a new edge arrives in that same cycle, the flag stays set.
- R10: For function codes 2 to 15, `func_req` follows `in_level` and no interrupt is raised. For codes 0 and 1, `func_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 16 | Control word write value |
| cfg_rd_data | output | 16 | Stored control word |
| out_val | input | 1 | Logical output value from software |
| irq_clear | input | 1 | One-cycle interrupt clear strobe |
| pad_in | input | 1 | Asynchronous pad input |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output data |
| pad_pull | output | 2 | Pull selection passed to the pad |
| pad_dom_sel | output | 1 | Supply-domain selection passed to the pad |
| in_level | output | 1 | Filtered, polarity-adjusted input |
| irq_flag | output | 1 | Sticky interrupt flag |
| func_req | output | 1 | Filtered input for non-GPIO function codes |

## Verification
The properties assume `cfg_wr_en` and `irq_clear` are single-cycle strobes driven from the clock domain. They also assume `pad_in` is the only asynchronous input. The stimulus changes every synchronous input half a period away from the rising edge. The pad is moved only at those same moments, so the synchroniser sees clean transitions. When interrupt behaviour is checked, each pad level is held well past the active filter window before the next change.

// File: rtl/gpio_pin_pkg.sv
// Shared types and constants for the GPIO pin controller.
// Assumes a 16-bit control word with fixed field positions.
package gpio_pin_pkg;

    typedef struct packed {
        logic       dir_in;
        logic [1:0] pull;
        logic       both_edges;
        logic       dom;
        logic       pol_true;
        logic       open_drain;
        logic       enable;
        logic [3:0] fn;
    } gpio_cfg_t;

    localparam logic [15:0] CFG_RESET = 16'hA400;
    localparam logic [15:0] CFG_MASK  = 16'hFE8F;

    // Field extraction from a control word.
    function automatic gpio_cfg_t cfg_unpack(input logic [15:0] w);
        gpio_cfg_t c;
        c.dir_in     = w[15];
        c.pull       = w[14:13];
        c.both_edges = w[12];
        c.dom        = w[11];
        c.pol_true   = w[10];
        c.open_drain = w[9];
        c.enable     = w[7];
        c.fn         = w[3:0];
        return c;
    endfunction

endpackage

// File: rtl/gpio_cfg_reg.sv
// Control word storage: keeps only defined bits, exposes decoded fields.
// Assumes wr_en is a single-cycle strobe in the clk domain.
module gpio_cfg_reg
    import gpio_pin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output gpio_cfg_t   cfg
);
    logic [15:0] word_q;

    // Capture a masked write, return to reset value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= CFG_RESET;
        else if (wr_en)
            word_q <= wr_data & CFG_MASK;
    end

    assign rd_data = word_q;
    assign cfg     = cfg_unpack(word_q);
endmodule

// File: rtl/gpio_in_filter.sv
// Input path: multi-flop synchroniser followed by a stable-count de-bouncer.
// Assumes pad_in is asynchronous; long_sel may change at any time.
module gpio_in_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int DB_SHORT    = 4,
    parameter int DB_LONG     = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_in,
    input  logic long_sel,
    output logic level
);
    localparam int CNT_W = $clog2(DB_LONG + 1);
    localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(DB_SHORT - 1);
    localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(DB_LONG - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   level_q;
    logic [CNT_W-1:0]       limit;

    // Shift the pad value through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[SYNC_STAGES-2:0], pad_in};
    end

    assign limit = long_sel ? LIM_LONG : LIM_SHORT;

    // Accept a new level after it differs for the full window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else if (sync_q[SYNC_STAGES-1] == level_q) begin
            cnt_q <= '0;
        end else if (cnt_q >= limit) begin
            cnt_q   <= '0;
            level_q <= sync_q[SYNC_STAGES-1];
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign level = level_q;
endmodule

// File: rtl/gpio_edge_irq.sv
// Edge detector and sticky interrupt flag on the filtered pad value.
// Assumes clear is a single-cycle strobe; polarity writes cause no edge.
module gpio_edge_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_level,
    input  logic pol_true,
    input  logic both_edges,
    input  logic irq_allow,
    input  logic clear,
    output logic flag
);
    logic prev_q;
    logic flag_q;
    logic rise_raw;
    logic fall_raw;
    logic active_rise;
    logic hit;

    // Remember the previous filtered value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= raw_level;
    end

    assign rise_raw    = raw_level & ~prev_q;
    assign fall_raw    = ~raw_level & prev_q;
    assign active_rise = pol_true ? rise_raw : fall_raw;
    assign hit = irq_allow & (both_edges ? (rise_raw | fall_raw) : active_rise);

    // Sticky flag: a new hit wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else
            flag_q <= (flag_q & ~clear) | hit;
    end

    assign flag = flag_q;
endmodule

// File: rtl/gpio_pin_ctrl.sv
// Top of the GPIO pin controller: register, input filter, interrupt, drive.
// Assumes all inputs except pad_in are synchronous to clk.
module gpio_pin_ctrl
    import gpio_pin_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DB_SHORT    = 4,
    parameter int DB_LONG     = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [15:0] cfg_wr_data,
    output logic [15:0] cfg_rd_data,
    input  logic        out_val,
    input  logic        irq_clear,
    input  logic        pad_in,
    output logic        pad_oe,
    output logic        pad_out,
    output logic [1:0]  pad_pull,
    output logic        pad_dom_sel,
    output logic        in_level,
    output logic        irq_flag,
    output logic        func_req
);
    gpio_cfg_t cfg;
    logic      raw_level;
    logic      gpio_fn;
    logic      drive_lvl;

    gpio_cfg_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .cfg     (cfg)
    );

    gpio_in_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .DB_SHORT    (DB_SHORT),
        .DB_LONG     (DB_LONG)
    ) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .long_sel (cfg.fn == 4'd0),
        .level    (raw_level)
    );

    assign gpio_fn = (cfg.fn <= 4'd1);

    gpio_edge_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_level  (raw_level),
        .pol_true   (cfg.pol_true),
        .both_edges (cfg.both_edges),
        .irq_allow  (gpio_fn),
        .clear      (irq_clear),
        .flag       (irq_flag)
    );

    // Output drive: polarity, then push-pull or open-drain, then enable.
    always_comb begin
        drive_lvl = cfg.pol_true ? out_val : ~out_val;
        pad_out   = cfg.open_drain ? 1'b0 : drive_lvl;
        pad_oe    = cfg.enable & ~cfg.dir_in & ~(cfg.open_drain & drive_lvl);
    end

    assign in_level    = cfg.pol_true ? raw_level : ~raw_level;
    assign func_req    = gpio_fn ? 1'b0 : in_level;
    assign pad_pull    = cfg.pull;
    assign pad_dom_sel = cfg.dom;
endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
// Property checker for gpio_pin_ctrl, attached by bind; observes ports only.
module gpio_pin_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [15:0] cfg_wr_data,
    input logic [15:0] cfg_rd_data,
    input logic        out_val,
    input logic        irq_clear,
    input logic        pad_in,
    input logic        pad_oe,
    input logic        pad_out,
    input logic [1:0]  pad_pull,
    input logic        pad_dom_sel,
    input logic        in_level,
    input logic        irq_flag,
    input logic        func_req
);
    p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> cfg_rd_data == ($past(cfg_wr_data) & 16'hFE8F));

    p_input_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[15] |-> !pad_oe);

    p_tristate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_data[7] |-> !pad_oe);

    p_od_no_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[9] |-> !pad_out);

    p_pull_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pad_pull == cfg_rd_data[14:13] && pad_dom_sel == cfg_rd_data[11]);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !irq_clear |=> irq_flag);

    p_alt_fn_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_flag && cfg_rd_data[3:0] >= 4'd2 |=> !irq_flag);

    p_gpio_fn_req_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[3:0] <= 4'd1 |-> !func_req);
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk u_chk (.*);

// File: tb/gpio_pin_ctrl_bench.sv
module gpio_pin_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wr_data = '0;
    logic [15:0] cfg_rd_data;
    logic        out_val = 1'b0;
    logic        irq_clear = 1'b0;
    logic        pad_in = 1'b0;
    logic        pad_oe;
    logic        pad_out;
    logic [1:0]  pad_pull;
    logic        pad_dom_sel;
    logic        in_level;
    logic        irq_flag;
    logic        func_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_pin_ctrl u_gpio_pin_ctrl (.*);

    // Drive table: {control word, out_val, expected pad_oe, expected pad_out}
    localparam logic [18:0] DRV [9] = '{
        {16'h0480, 1'b1, 1'b1, 1'b1},
        {16'h0480, 1'b0, 1'b1, 1'b0},
        {16'h0080, 1'b1, 1'b1, 1'b0},
        {16'h0080, 1'b0, 1'b1, 1'b1},
        {16'h0400, 1'b1, 1'b0, 1'b1},
        {16'h8480, 1'b1, 1'b0, 1'b1},
        {16'h0680, 1'b1, 1'b0, 1'b0},
        {16'h0680, 1'b0, 1'b1, 1'b0},
        {16'h0280, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_irq();
        @(negedge clk);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // Reset state
        chk("R1 reset word", cfg_rd_data, 16'hA400);
        chk("R2 reset oe", {15'd0, pad_oe}, 16'd0);
        chk("R6 reset pull", {14'd0, pad_pull}, 16'd1);
        chk("R9 reset irq", {15'd0, irq_flag}, 16'd0);
        chk("R3 reset in_level", {15'd0, in_level}, 16'd0);

        // R1/R6: all-ones write
        wr(16'hFFFF);
        chk("R1 masked readback", cfg_rd_data, 16'hFE8F);
        chk("R6 pull", {14'd0, pad_pull}, 16'd3);
        chk("R6 domain", {15'd0, pad_dom_sel}, 16'd1);

        // R2 R3 R4 R5: output drive table
        for (int i = 0; i < 9; i++) begin
            wr(DRV[i][18:3]);
            out_val = DRV[i][2];
            wait_n(1);
            chk("R2 R3 R4 R5 drive oe", {15'd0, pad_oe}, {15'd0, DRV[i][1]});
            chk("R3 R5 drive out", {15'd0, pad_out}, {15'd0, DRV[i][0]});
        end

        // R7 normal de-bounce timing, R8 single rising edge
        wr(16'h8481);
        clr_irq();
        pad_in = 1'b1;
        wait_n(5);
        chk("R7 not yet accepted", {15'd0, in_level}, 16'd0);
        wait_n(1);
        chk("R7 accepted after window", {15'd0, in_level}, 16'd1);
        wait_n(2);
        chk("R8 rising sets irq", {15'd0, irq_flag}, 16'd1);
        wait_n(20);
        chk("R9 flag sticky", {15'd0, irq_flag}, 16'd1);
        clr_irq();
        chk("R9 cleared", {15'd0, irq_flag}, 16'd0);
        pad_in = 1'b0;
        wait_n(10);
        chk("R7 falls", {15'd0, in_level}, 16'd0);
        chk("R8 falling ignored single edge", {15'd0, irq_flag}, 16'd0);

        // R7 glitch shorter than window
        pad_in = 1'b1;
        wait_n(3);
        pad_in = 1'b0;
        wait_n(10);
        chk("R7 glitch dropped", {15'd0, in_level}, 16'd0);

        // R8 both edges
        wr(16'h9481);
        pad_in = 1'b1;
        wait_n(10);
        chk("R8 both rising", {15'd0, irq_flag}, 16'd1);
        clr_irq();
        pad_in = 1'b0;
        wait_n(10);
        chk("R8 both falling", {15'd0, irq_flag}, 16'd1);
        clr_irq();

        // R3 inverted polarity, R8 edge follows adjusted level
        wr(16'h8081);
        wait_n(2);
        chk("R3 inverted input", {15'd0, in_level}, 16'd1);
        chk("R8 polarity write no irq", {15'd0, irq_flag}, 16'd0);
        pad_in = 1'b1;
        wait_n(10);
        chk("R3 inverted high pad", {15'd0, in_level}, 16'd0);
        chk("R8 adjusted fall ignored", {15'd0, irq_flag}, 16'd0);
        pad_in = 1'b0;
        wait_n(10);
        chk("R8 adjusted rise sets", {15'd0, irq_flag}, 16'd1);
        clr_irq();

        // R7 long de-bounce with function code 0
        wr(16'h8480);
        pad_in = 1'b1;
        wait_n(40);
        pad_in = 1'b0;
        wait_n(2);
        chk("R7 long window drops 40-cycle pulse", {15'd0, in_level}, 16'd0);
        wait_n(70);
        pad_in = 1'b1;
        wait_n(65);
        chk("R7 long not yet accepted", {15'd0, in_level}, 16'd0);
        wait_n(1);
        chk("R7 long accepted", {15'd0, in_level}, 16'd1);
        wait_n(2);
        chk("R8 long irq", {15'd0, irq_flag}, 16'd1);
        clr_irq();

        // R10 alternate function code
        wr(16'h8485);
        pad_in = 1'b0;
        wait_n(10);
        chk("R10 req low", {15'd0, func_req}, 16'd0);
        pad_in = 1'b1;
        wait_n(10);
        chk("R10 req follows", {15'd0, func_req}, 16'd1);
        chk("R10 no irq", {15'd0, irq_flag}, 16'd0);
        wr(16'h8481);
        chk("R10 gpio code req low", {15'd0, func_req}, 16'd0);
        chk("R10 in_level still high", {15'd0, in_level}, 16'd1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule